// File: doc/BRIEF.md
# Six-Pin General-Purpose I/O Port with Per-Pin Open-Drain

This block is one general-purpose I/O port of six pins, controlled through a small register interface. Software sets a direction bit, an output data bit and an open-drain select bit for each pin. The block turns those bits into an output-enable and an output value for each pad buffer. Input levels arrive from the pads and pass through a two-flop synchroniser. A read-only port register then gives, bit by bit, either the data register (for a pin set as output) or the synchronised pin level (for a pin set as input).

A pin with its open-drain select set only pulls low. When its data bit is 1, the pad driver is turned off so that an external pull-up sets the level. A pin with the select clear drives both levels as a push-pull output.

Two standby controls are provided. Hardware standby clears every register in the same way as reset. Software standby freezes the register contents and the synchronised pin levels, so that reads return what they showed before standby began.

Top module: `gpio6_port`

## Requirements
- R1: After reset, the direction, data and open-drain registers read 0x00, every padOe bit is 0, and the port register shows the synchronised pin levels.
- R2: A write with wrEn=1 to address 0 (direction), 1 (data) or 3 (open-drain) stores bits 5:0 at the next rising clock edge. Bits 7:6 of every register read back as zero.
- R3: A write to address 2 (port register) changes no register and no pad output.
- R4: Reading address 2 returns, for each bit i in 5:0, data bit i when direction bit i is 1, and the synchronised level of pinIn[i] when direction bit i is 0.
- R5: A change on pinIn shows in the port register after exactly two rising clock edges and not after one.
- R6: For a pin whose open-drain bit is 0, padOe equals its direction bit and padOut equals its data bit.
- R7: For a pin whose open-drain bit is 1, padOe is 1 only when its direction bit is 1 and its data bit is 0. padOut equals its data bit.
- R8: While hwStandby is 1, the direction, data and open-drain registers clear to zero at the next edge, and writes are ignored.
- R9: While swStandby is 1 and hwStandby is 0, writes are ignored and the synchronised pin levels hold, so port-register reads do not change when the pins change.
- R10: When hwStandby and swStandby are both 1, hardware standby takes priority and the registers clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hwStandby | input | 1 | Hardware standby: clears the registers |
| swStandby | input | 1 | Software standby: holds the registers and the sampled pins |
| addr | input | 2 | Register select (0 direction, 1 data, 2 port, 3 open-drain) |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the register at addr |
| pinIn | input | 6 | Pad input levels |
| padOe | output | 6 | Per-pin pad driver enable |
| padOut | output | 6 | Per-pin pad output value |

## Verification
The hardest case to reach is software standby with pins changing underneath it. A held port value can only be told apart from a live one if some pins are inputs, the pin levels change while standby is active, and the bench waits longer than the synchroniser delay before reading. The directed stimulus sets a mixed direction pattern, enters standby, flips every pin, attempts writes, and waits several cycles before reading all four registers. It then releases standby and confirms that the new levels appear two edges later. Random writes and pin changes, checked against a bench model, cover the mixed open-drain and push-pull combinations.

// File: rtl/gpio6_pkg.sv
package gpio6_pkg;

  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_DIR  = 2'd0,
    SEL_DATA = 2'd1,
    SEL_PORT = 2'd2,
    SEL_ODC  = 2'd3
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrAll;   // hardware standby clear
    logic freeze;   // software standby hold
    logic wrDir;
    logic wrData;
    logic wrOdc;
  } ctrlStrobes_t;

endpackage

// File: rtl/gpio6_ctrl.sv
module gpio6_ctrl
  import gpio6_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hwStandby,
  input  logic              swStandby,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  output ctrlStrobes_t      strobes
);

  logic wrOk;

  always_comb begin
    wrOk           = wrEn & ~hwStandby & ~swStandby;
    strobes.clrAll = hwStandby;
    strobes.freeze = swStandby & ~hwStandby;
    strobes.wrDir  = wrOk & (addr == SEL_DIR);
    strobes.wrData = wrOk & (addr == SEL_DATA);
    strobes.wrOdc  = wrOk & (addr == SEL_ODC);
  end

  // R2
  one_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrDir, strobes.wrData, strobes.wrOdc}));

  // R3
  port_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == SEL_PORT) |-> !(strobes.wrDir || strobes.wrData || strobes.wrOdc));

  // R10
  hw_over_sw_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hwStandby && swStandby) |-> (strobes.clrAll && !strobes.freeze));

endmodule

// File: rtl/gpio6_datapath.sv
module gpio6_datapath
  import gpio6_pkg::*;
#(
  parameter int PIN_W       = 6,
  parameter int REG_W       = 8,
  parameter int SYNC_STAGES = 2
)(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  input  logic [PIN_W-1:0]  pinIn,
  output logic [PIN_W-1:0]  padOe,
  output logic [PIN_W-1:0]  padOut
);

  localparam int RSV_W = REG_W - PIN_W;

  logic [PIN_W-1:0] dirReg, dataReg, odcReg;
  logic [PIN_W-1:0] syncQ [SYNC_STAGES];
  logic [PIN_W-1:0] pinSync, portView;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg  <= '0;
      dataReg <= '0;
      odcReg  <= '0;
    end else if (strobes.clrAll) begin
      dirReg  <= '0;
      dataReg <= '0;
      odcReg  <= '0;
    end else begin
      if (strobes.wrDir)  dirReg  <= wrData[PIN_W-1:0];
      if (strobes.wrData) dataReg <= wrData[PIN_W-1:0];
      if (strobes.wrOdc)  odcReg  <= wrData[PIN_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
    end else if (!strobes.freeze) begin
      syncQ[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
    end
  end

  assign pinSync = syncQ[SYNC_STAGES-1];

  for (genvar i = 0; i < PIN_W; i++) begin : g_pin
    assign portView[i] = dirReg[i] ? dataReg[i] : pinSync[i];
    assign padOut[i]   = dataReg[i];
    // open-drain pins release the pad when driving a one
    assign padOe[i]    = dirReg[i] & (~odcReg[i] | ~dataReg[i]);
  end

  always_comb begin
    case (addr)
      SEL_DIR:  rdData = {{RSV_W{1'b0}}, dirReg};
      SEL_DATA: rdData = {{RSV_W{1'b0}}, dataReg};
      SEL_PORT: rdData = {{RSV_W{1'b0}}, portView};
      default:  rdData = {{RSV_W{1'b0}}, odcReg};
    endcase
  end

  // R8
  hw_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrAll |=> (dirReg == '0 && dataReg == '0 && odcReg == '0));

  // R9
  sw_reg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.freeze |=> ($stable(dirReg) && $stable(dataReg) && $stable(odcReg)));

  // R9
  sw_pin_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.freeze |=> $stable(pinSync));

  // R7
  odc_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrData && wrData[0] && odcReg[0] && !strobes.wrOdc) |=> !padOe[0]);

endmodule

// File: rtl/gpio6_port.sv
module gpio6_port
  import gpio6_pkg::*;
#(
  parameter int PIN_W       = 6,
  parameter int REG_W       = 8,
  parameter int SYNC_STAGES = 2
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hwStandby,
  input  logic              swStandby,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  input  logic [PIN_W-1:0]  pinIn,
  output logic [PIN_W-1:0]  padOe,
  output logic [PIN_W-1:0]  padOut
);

  ctrlStrobes_t strobes;

  gpio6_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hwStandby (hwStandby),
    .swStandby (swStandby),
    .addr      (addr),
    .wrEn      (wrEn),
    .strobes   (strobes)
  );

  gpio6_datapath #(
    .PIN_W       (PIN_W),
    .REG_W       (REG_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .addr    (addr),
    .wrData  (wrData),
    .rdData  (rdData),
    .pinIn   (pinIn),
    .padOe   (padOe),
    .padOut  (padOut)
  );

endmodule

// File: tb/sim_gpio6_port.sv
`timescale 1ns/1ps
module sim_gpio6_port;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hwStandby = 1'b0, swStandby = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic [5:0] pinIn = 6'd0;
  logic [5:0] padOe, padOut;

  int checks = 0, failures = 0;
  logic [5:0] dirM = 0, dataM = 0, odcM = 0, pinM = 0;

  always #2 clk = ~clk;

  gpio6_port u0 (.clk(clk), .rstN(rstN), .hwStandby(hwStandby), .swStandby(swStandby),
                 .addr(addr), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
                 .pinIn(pinIn), .padOe(padOe), .padOut(padOut));

  function automatic logic [7:0] expPort();
    return {2'b00, (dirM & dataM) | (~dirM & pinM)};
  endfunction
  function automatic logic [5:0] expOe();
    return dirM & (~odcM | ~dataM);
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] v);
    addr = a; #0.5; v = rdData;
  endtask

  // one write; the model follows only when no standby blocks it
  task automatic busWrite(logic [1:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
    if (!hwStandby && !swStandby) begin
      if (a == 2'd0) dirM = d[5:0];
      if (a == 2'd1) dataM = d[5:0];
      if (a == 2'd3) odcM = d[5:0];
    end
  endtask

  task automatic setPins(logic [5:0] v);
    @(negedge clk); pinIn = v;
    repeat (2) @(negedge clk);
    pinM = v;
  endtask

  task automatic checkAll(string tag);
    logic [7:0] v;
    rd(2'd0, v); check({tag, " R2 dir"}, v, {2'b00, dirM});
    rd(2'd1, v); check({tag, " R2 data"}, v, {2'b00, dataM});
    rd(2'd3, v); check({tag, " R2 odc"}, v, {2'b00, odcM});
    rd(2'd2, v); check({tag, " R4 port"}, v, expPort());
    check({tag, " R6/R7 oe"}, {2'b00, padOe}, {2'b00, expOe()});
    check({tag, " R6/R7 out"}, {2'b00, padOut}, {2'b00, dataM});
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5eed));
    pinIn = 6'h2d;
    #1 check("R1 oe during reset", {2'b00, padOe}, 8'h00);
    #9 rstN = 1'b1;
    setPins(6'h2d);
    checkAll("R1 reset");

    // R2 writes with reserved bits set
    busWrite(2'd0, 8'hff); busWrite(2'd1, 8'hea); busWrite(2'd3, 8'hc0);
    checkAll("R2 write");
    // R6 push-pull mixed
    busWrite(2'd0, 8'h3c); busWrite(2'd1, 8'h15); busWrite(2'd3, 8'h00);
    checkAll("R6 pushpull");
    // R7 open-drain all pins, output
    busWrite(2'd0, 8'h3f); busWrite(2'd3, 8'h3f); busWrite(2'd1, 8'h0f);
    checkAll("R7 opendrain");
    check("R7 oe", {2'b00, padOe}, 8'h30);

    // R3 write to port register ignored
    busWrite(2'd2, 8'h2a);
    checkAll("R3 port write");

    // R5 synchroniser latency
    busWrite(2'd0, 8'h00);
    setPins(6'h00);
    @(negedge clk); pinIn = 6'h3f;
    @(negedge clk); rd(2'd2, v); check("R5 after one edge", v, 8'h00);
    @(negedge clk); rd(2'd2, v); check("R5 after two edges", v, 8'h3f);
    pinM = 6'h3f;

    // R4 mixed direction
    busWrite(2'd1, 8'h05); busWrite(2'd0, 8'h0f); busWrite(2'd3, 8'h02);
    setPins(6'h1a);
    checkAll("R4 mixed");

    // R9 software standby: writes and pin changes held
    @(negedge clk); swStandby = 1'b1;
    busWrite(2'd0, 8'h30); busWrite(2'd1, 8'h3f); busWrite(2'd3, 8'h00);
    @(negedge clk); pinIn = ~pinIn;
    repeat (4) @(negedge clk);
    checkAll("R9 swstandby");
    @(negedge clk); swStandby = 1'b0;
    pinM = pinIn;
    repeat (2) @(negedge clk);
    checkAll("R9 release");

    // R10 both standbys: hardware wins
    @(negedge clk); swStandby = 1'b1; hwStandby = 1'b1;
    busWrite(2'd0, 8'h3f);
    dirM = 0; dataM = 0; odcM = 0;
    checkAll("R10 both");
    @(negedge clk); swStandby = 1'b0;
    // R8 hardware standby alone, writes ignored
    busWrite(2'd1, 8'h3f);
    checkAll("R8 hwstandby");
    @(negedge clk); hwStandby = 1'b0;

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op = $urandom % 3;
      if (op == 0) setPins(6'($urandom));
      else busWrite(2'($urandom), 8'($urandom));
      checkAll("random");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule